// File: doc/BRIEF.md
# Light-Load Burst and Supply Holdup Mode Controller

This block decides, cycle by cycle, whether the PWM stage of a flyback controller may switch normally, must stay quiet, or must be forced to deliver small packets of energy to keep its own supply alive. It takes digitized comparator flags from the feedback path and the supply path and produces a normal-switching enable, a forced-pulse request and a two-bit mode code. It does not generate PWM and contains no comparators.

Two hysteresis loops run side by side. The burst loop stops switching when the feedback flag says the level has dropped under the low burst threshold, and it lets switching resume only once feedback reaches the high burst threshold. The holdup loop watches the supply: when feedback sits below the holdup-permit level and the supply falls to its entry level, the block overrides burst blanking and asks for one minimal forced pulse per oscillator cycle until the supply climbs back to the exit level. The burst loop keeps tracking feedback while holdup is active, so the mode that follows holdup is the one the feedback currently calls for.

All flag inputs cross two flip-flop stages before use. The oscillator tick is a same-clock pulse and is used directly.

Top module: `burst_holdup_ctrl`

## Requirements
- R1: While reset is applied and right after it, mode_o is 2'b00 (normal), sw_enable_o is 1 and force_pulse_o is 0.
- R2: Each of the five flag inputs passes two synchronizing flops; a flag change sampled at one rising edge changes the outputs at the third rising edge after it, not earlier.
- R3: In normal mode, an asserted fb_low_i moves the block to burst-off, mode_o 2'b01, with sw_enable_o 0.
- R4: In burst-off, the block stays blanked until fb_high_i is asserted; dropping fb_low_i alone does not resume switching. fb_high_i returns mode_o to 2'b00.
- R5: When sup_low_i and fb_hold_ok_i are both asserted, the block enters holdup, mode_o 2'b10, whatever the burst state; sw_enable_o is 0 in holdup.
- R6: Holdup ends when sup_high_i is asserted; the mode then becomes 2'b01 or 2'b00 per the burst loop.
- R7: Holdup is entered only while fb_hold_ok_i is asserted and is left as soon as fb_hold_ok_i drops; sup_low_i alone has no effect on mode_o.
- R8: force_pulse_o is a one-cycle pulse in the cycle after each osc_tick_i sampled while the block is (or is just becoming) in holdup, and is 0 whenever mode_o is not 2'b10.
- R9: The burst loop keeps following fb_low_i and fb_high_i during holdup; leaving holdup after fb_high_i was seen gives mode_o 2'b00.
- R10: mode_o never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fb_low_i | input | 1 | Feedback has fallen to the low burst threshold |
| fb_high_i | input | 1 | Feedback has risen to the high burst threshold |
| fb_hold_ok_i | input | 1 | Feedback is below the level that permits holdup |
| sup_low_i | input | 1 | Supply has dropped to the holdup entry level |
| sup_high_i | input | 1 | Supply has recovered to the holdup exit level |
| osc_tick_i | input | 1 | One-cycle pulse per oscillator period, same clock domain |
| sw_enable_o | output | 1 | Normal PWM switching allowed |
| force_pulse_o | output | 1 | Request for one minimal-energy forced pulse |
| mode_o | output | 2 | 00 normal, 01 burst-off, 10 holdup |

## Verification
The two loops can act in the same cycle: feedback reaching the high burst level (burst release) can coincide with the supply reaching its holdup entry level, and an oscillator tick can coincide with the last cycle of holdup. The bench provokes the first by driving fb_high_i, sup_low_i and fb_hold_ok_i on the same edge, and the second through a long stretch of random flag changes against a steady tick train. A behavioural reference model in the bench, fed the same stimulus, judges each cycle's mode, enable and pulse, so holdup priority over burst and the absence of a pulse after holdup exit are checked where they collide.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

  localparam int NUM_FLAGS = 5;

  localparam int FL_FB_LOW   = 0;
  localparam int FL_FB_HIGH  = 1;
  localparam int FL_FB_OK    = 2;
  localparam int FL_SUP_LOW  = 3;
  localparam int FL_SUP_HIGH = 4;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_BURST  = 2'b01,
    MODE_HOLD   = 2'b10
  } bhc_mode_e;

endpackage

// File: rtl/bhc_rst_sync.sv
module bhc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] shreg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      shreg_q <= '0;
    end else begin
      shreg_q <= {shreg_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = shreg_q[STAGES-1];

endmodule

// File: rtl/bhc_sync.sv
module bhc_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = d_i;
      end else begin : g_rest
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else begin
          stage_q[s] <= stage_d;
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/bhc_burst.sv
module bhc_burst (
  input  logic clk,
  input  logic rst_n,
  input  logic fb_low,
  input  logic fb_high,
  output logic blank_q
);

  logic blank_d;

  always_comb begin
    blank_d = blank_q;
    if (blank_q) begin
      if (fb_high) blank_d = 1'b0;
    end else begin
      if (fb_low) blank_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= 1'b0;
    end else begin
      blank_q <= blank_d;
    end
  end

  p_burst_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_q && fb_low) |=> blank_q);

  p_burst_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_q && !fb_high) |=> blank_q);

endmodule

// File: rtl/bhc_holdup.sv
module bhc_holdup (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_low,
  input  logic sup_high,
  input  logic fb_ok,
  output logic hold_d,
  output logic hold_q
);

  always_comb begin
    if (hold_q) begin
      hold_d = fb_ok && !sup_high;
    end else begin
      hold_d = fb_ok && sup_low;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
    end
  end

  p_hold_enter_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && sup_low && fb_ok) |=> hold_q);

  p_hold_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && sup_high) |=> !hold_q);

  p_hold_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_ok |=> !hold_q);

endmodule

// File: rtl/burst_holdup_ctrl.sv
module burst_holdup_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fb_low_i,
  input  logic       fb_high_i,
  input  logic       fb_hold_ok_i,
  input  logic       sup_low_i,
  input  logic       sup_high_i,
  input  logic       osc_tick_i,
  output logic       sw_enable_o,
  output logic       force_pulse_o,
  output logic [1:0] mode_o
);
  import bhc_pkg::*;

  logic                 rst_int_n;
  logic [NUM_FLAGS-1:0] flags_raw;
  logic [NUM_FLAGS-1:0] flags_s;
  logic                 blank_q;
  logic                 hold_d;
  logic                 hold_q;
  logic                 pulse_d;
  logic                 pulse_q;
  bhc_mode_e            mode_sel;

  bhc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  always_comb begin
    flags_raw              = '0;
    flags_raw[FL_FB_LOW]   = fb_low_i;
    flags_raw[FL_FB_HIGH]  = fb_high_i;
    flags_raw[FL_FB_OK]    = fb_hold_ok_i;
    flags_raw[FL_SUP_LOW]  = sup_low_i;
    flags_raw[FL_SUP_HIGH] = sup_high_i;
  end

  bhc_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (flags_raw),
    .q_o   (flags_s)
  );

  bhc_burst u_burst (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .fb_low  (flags_s[FL_FB_LOW]),
    .fb_high (flags_s[FL_FB_HIGH]),
    .blank_q (blank_q)
  );

  bhc_holdup u_hold (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sup_low  (flags_s[FL_SUP_LOW]),
    .sup_high (flags_s[FL_SUP_HIGH]),
    .fb_ok    (flags_s[FL_FB_OK]),
    .hold_d   (hold_d),
    .hold_q   (hold_q)
  );

  // Forced pulse: aligned with the cycle in which holdup is registered.
  always_comb begin
    pulse_d = hold_d && osc_tick_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  // Holdup overrides burst blanking.
  always_comb begin
    if (hold_q) begin
      mode_sel = MODE_HOLD;
    end else if (blank_q) begin
      mode_sel = MODE_BURST;
    end else begin
      mode_sel = MODE_NORMAL;
    end
  end

  assign mode_o        = mode_sel;
  assign sw_enable_o   = (mode_sel == MODE_NORMAL);
  assign force_pulse_o = pulse_q;

  p_mode_legal_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    mode_o != 2'b11);

  p_pulse_in_hold_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    force_pulse_o |-> (mode_o == MODE_HOLD) && !sw_enable_o);

  p_pulse_src_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    force_pulse_o |-> $past(osc_tick_i));

  p_hold_over_burst_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    hold_q |-> (mode_o == MODE_HOLD));

endmodule

// File: tb/burst_holdup_ctrl_tb_top.sv
module burst_holdup_ctrl_tb_top;

  localparam int WATCHDOG = 100000;
  localparam int TICK_DIV = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fb_low, fb_high, fb_ok, sup_low, sup_high, osc_tick;
  logic       sw_enable, force_pulse;
  logic [1:0] mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit tick_en = 0;
  int tick_cnt = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  burst_holdup_ctrl dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .fb_low_i      (fb_low),
    .fb_high_i     (fb_high),
    .fb_hold_ok_i  (fb_ok),
    .sup_low_i     (sup_low),
    .sup_high_i    (sup_high),
    .osc_tick_i    (osc_tick),
    .sw_enable_o   (sw_enable),
    .force_pulse_o (force_pulse),
    .mode_o        (mode)
  );

  // ---------------- behavioural reference model ----------------
  bit [4:0] pipe[$];
  int  rel_edges;
  bit  m_blank, m_hold, m_pulse;

  function automatic int exp_mode();
    if (m_hold) return 2;
    if (m_blank) return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe = '{5'd0, 5'd0};
      rel_edges = 0;
      m_blank = 0; m_hold = 0; m_pulse = 0;
    end else if (rel_edges < 2) begin
      rel_edges++;
    end else begin
      bit [4:0] v;
      bit nh;
      v = pipe.pop_front();
      pipe.push_back({sup_high, sup_low, fb_ok, fb_high, fb_low});
      // v: [0] fb low, [1] fb high, [2] fb ok, [3] sup low, [4] sup high
      if (m_hold) nh = v[2] && !v[4];
      else        nh = v[2] && v[3];
      m_pulse = nh && osc_tick;
      m_hold  = nh;
      if (m_blank) m_blank = !v[1];
      else         m_blank = v[0];
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (!done && rst_n === 1'b1) begin
      check(cur_req, int'(mode), exp_mode(), "mode vs model");
      check(cur_req, int'(sw_enable), int'(exp_mode() == 0), "sw_enable vs model");
      check("R8", int'(force_pulse), int'(m_pulse), "force_pulse vs model");
      check("R10", int'(mode == 2'b11), 0, "illegal mode code");
    end
  end

  // Oscillator tick source.
  always @(negedge clk) begin
    if (tick_en) begin
      tick_cnt = (tick_cnt + 1) % TICK_DIV;
      osc_tick = (tick_cnt == 0);
    end else begin
      tick_cnt = 0;
      osc_tick = 1'b0;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int pcount;
    rst_n = 1'b0;
    fb_low = 0; fb_high = 0; fb_ok = 0; sup_low = 0; sup_high = 0; osc_tick = 0;
    wait_n(3);
    check("R1", int'(mode), 0, "mode in reset");
    check("R1", int'(sw_enable), 1, "sw_enable in reset");
    check("R1", int'(force_pulse), 0, "force_pulse in reset");
    rst_n = 1'b1;
    wait_n(5);
    check("R1", int'(mode), 0, "mode after reset");
    check("R1", int'(sw_enable), 1, "sw_enable after reset");

    // R2 latency and R3 burst entry
    cur_req = "R3";
    fb_low = 1;
    wait_n(2);
    check("R2", int'(mode), 0, "mode two edges after flag");
    wait_n(1);
    check("R2", int'(mode), 1, "mode three edges after flag");
    check("R3", int'(sw_enable), 0, "sw_enable in burst");

    // R4 hysteresis
    cur_req = "R4";
    fb_low = 0;
    wait_n(6);
    check("R4", int'(mode), 1, "burst held without high flag");
    fb_high = 1;
    wait_n(3);
    check("R4", int'(mode), 0, "resume on high flag");
    fb_high = 0;
    fb_low = 1;
    wait_n(4);
    fb_low = 0;
    check("R3", int'(mode), 1, "burst re-entry");

    // R7 supply low alone
    cur_req = "R7";
    sup_low = 1;
    wait_n(6);
    check("R7", int'(mode), 1, "sup_low alone ignored");

    // R5 holdup overrides burst, R8 pulses
    cur_req = "R5";
    fb_ok = 1;
    tick_en = 1;
    wait_n(4);
    check("R5", int'(mode), 2, "holdup entered over burst");
    check("R5", int'(sw_enable), 0, "sw_enable in holdup");
    pcount = 0;
    for (int i = 0; i < 40; i++) begin
      wait_n(1);
      if (force_pulse) pcount++;
    end
    check("R8", pcount, 40 / TICK_DIV, "forced pulses in 40 cycles");

    // R9 burst tracked in holdup, R6 exit
    cur_req = "R9";
    fb_high = 1;
    wait_n(4);
    check("R9", int'(mode), 2, "holdup stays with high fb");
    sup_low = 0; sup_high = 1;
    wait_n(4);
    check("R6", int'(mode), 0, "exit to normal after fb high seen");
    fb_high = 0; sup_high = 0;

    // R7 exit on feedback permit loss
    cur_req = "R7";
    fb_low = 1;
    wait_n(4);
    fb_low = 0;
    sup_low = 1;
    wait_n(4);
    check("R5", int'(mode), 2, "holdup from burst");
    fb_ok = 0;
    wait_n(4);
    check("R7", int'(mode), 1, "exit to burst on permit loss");
    pcount = 0;
    for (int i = 0; i < 20; i++) begin
      wait_n(1);
      if (force_pulse) pcount++;
    end
    check("R8", pcount, 0, "no pulses outside holdup");

    // Same-cycle collision: burst release and holdup entry together
    cur_req = "R5";
    fb_high = 1; fb_ok = 1; sup_low = 1;
    wait_n(3);
    check("R5", int'(mode), 2, "collision resolves to holdup");
    fb_high = 0; sup_low = 0; sup_high = 1;
    wait_n(3);
    check("R6", int'(mode), 0, "collision exit to normal");
    sup_high = 0; fb_ok = 0;
    wait_n(4);

    // Random flag activity against the reference model
    cur_req = "R6";
    for (int i = 0; i < 3000; i++) begin
      if ((i % 3) == 0) begin
        int r;
        r = $urandom;
        fb_low   = r[0];
        fb_high  = r[1] & r[2];
        fb_ok    = r[3] | r[4];
        sup_low  = r[5];
        sup_high = r[6] & r[7];
      end
      wait_n(1);
    end
    wait_n(4);
    finish_run();
  end

endmodule